// File: doc/BRIEF.md
# PCM Sample FIFO and DMA Request Controller

This block sits between a processor bus and a PCM serialiser. It owns one sample queue per direction. The processor, or a DMA engine acting for it, fills the transmit queue through a data register, and the serialiser drains it with a pop strobe. The serialiser fills the receive queue with a push strobe, and the processor drains it through the same data register. Four level comparators, one pair per direction, turn the fill counts into a data request and an urgent "panic" request. A control/status register reports what the queues need, and an interrupt line summarises the enabled conditions.

The serialiser runs from a slower PCM bit clock. That clock is presented here as a one-cycle strobe, `pcm_tick`, in the system clock domain. Two actions take effect only on PCM clock edges. A flush requested through a clear bit empties its queue on the second PCM edge after the write. A value written to the echo bit is read back only after it has passed two PCM edges. Software toggles the echo bit and waits for the new value to come back, which confirms that earlier control writes have reached the PCM side.

Top module: `pcm_fifo_dreq`

## Requirements
- R1: After reset, all five outputs `tx_dreq`, `tx_panic`, `rx_dreq`, `rx_panic` and `irq` are low. Reading the control word (address 0) returns 0x00220000. Reading the level word (address 2) returns 0x10303020, which holds transmit panic 0x10 in bits 31:24, receive panic 0x30 in bits 23:16, transmit request 0x30 in bits 15:8 and receive request 0x20 in bits 7:0.
- R2: A bus write to address 1 appends a word to the 64-word transmit queue, and is ignored when the queue is full. An accepted `tx_pop` presents the oldest word on `tx_data` one clock later, in write order.
- R3: An accepted `rx_push` appends `rx_data` to the 64-word receive queue. A bus read of address 1 returns the oldest word on `cpu_rdata` one clock later. A read of an empty queue removes nothing.
- R4: While DMA is enabled (control bit 9), `tx_dreq` is high when the transmit count is below the transmit request level, and `tx_panic` is high when it is below the transmit panic level. Both reflect the count one clock after it changes.
- R5: While DMA is enabled, `rx_dreq` is high when the receive count is above the receive request level, and `rx_panic` is high when it is above the receive panic level. Both reflect the count one clock after it changes.
- R6: With DMA disabled, all four request outputs are low one clock later, whatever the queue counts.
- R7: The control word reports these flags: bit 21 high for an empty transmit queue, bit 20 high for a non-empty receive queue, bit 17 high for transmit count below its request level, and bit 18 high for receive count above its request level. The flags do not depend on DMA enable.
- R8: A `tx_pop` while transmit is on and the queue is empty sets the sticky bit 15. An `rx_push` while receive is on and the queue is full sets the sticky bit 16 and drops the word. Writing 1 to either bit in the control word clears it.
- R9: Writing 1 to control bit 3 (transmit) or bit 4 (receive) empties that queue on the second `pcm_tick` after the write. The bit reads as 1 until then, and the queue keeps its contents until then.
- R10: The value written to control bit 24 is returned on readback of bit 24 only after the second `pcm_tick` that follows the write.
- R11: Address 3 holds the interrupt enables and address 4 returns the live conditions, with receive error at bit 3, transmit error at bit 2, the receive request flag at bit 1 and the transmit request flag at bit 0. `irq` is high one clock after any enabled condition is true.
- R12: Transmit on (control bit 2) and receive on (control bit 1) gate the serialiser side. A `tx_pop` while transmit is off, or an `rx_push` while receive is off, changes neither queue nor any error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register address: 0 control, 1 data, 2 levels, 3 irq enable, 4 irq status |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid the clock after the read strobe |
| pcm_tick | input | 1 | One-cycle strobe per PCM clock edge |
| tx_pop | input | 1 | Serialiser takes a transmit word |
| tx_data | output | 32 | Transmit word, valid the clock after an accepted pop |
| rx_push | input | 1 | Serialiser delivers a receive word |
| rx_data | input | 32 | Receive word |
| tx_dreq | output | 1 | Transmit data request |
| tx_panic | output | 1 | Transmit urgent request |
| rx_dreq | output | 1 | Receive data request |
| rx_panic | output | 1 | Receive urgent request |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue count shows up at the request outputs one clock after the operation that caused it. It also shows in the status flags of the next control-word read, so the bench compares all four request lines after every random push or pop against counts it tracks itself. A corrupted storage pointer only becomes visible when the affected word reaches `tx_data` or `cpu_rdata`, which can be up to 64 operations later, so every drained word is compared with the bench's own queue. Flush and echo timing faults are visible only on the exact PCM tick, so those are read back after each individual tick.

// File: rtl/pcm_fifo_dreq_pkg.sv
package pcm_fifo_dreq_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_DATA   = 3'd1,
    RA_LEVELS = 3'd2,
    RA_IRQEN  = 3'd3,
    RA_IRQST  = 3'd4
  } reg_addr_e;

  // control word bit positions
  localparam int B_RXON  = 1;
  localparam int B_TXON  = 2;
  localparam int B_TXCLR = 3;
  localparam int B_RXCLR = 4;
  localparam int B_DMAEN = 9;
  localparam int B_TXERR = 15;
  localparam int B_RXERR = 16;
  localparam int B_TXW   = 17;
  localparam int B_RXR   = 18;
  localparam int B_RXD   = 20;
  localparam int B_TXE   = 21;
  localparam int B_ECHO  = 24;

  // interrupt bit positions
  localparam int I_TXW   = 0;
  localparam int I_RXR   = 1;
  localparam int I_TXERR = 2;
  localparam int I_RXERR = 3;
  localparam int IRQ_W   = 4;

  localparam logic [31:0] LEVELS_RST = 32'h1030_3020;

endpackage

// File: rtl/pcm_fifo_dreq_store.sv
module pcm_fifo_dreq_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt;

  // storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/pcm_fifo_dreq_mark.sv
module pcm_fifo_dreq_mark #(
  parameter int LW    = 7,
  parameter int FW    = 8,
  parameter bit ABOVE = 1'b0,
  localparam int CW   = (LW > FW) ? LW : FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [FW-1:0] req_lvl,
  input  logic [FW-1:0] panic_lvl,
  output logic          need,
  output logic          dreq,
  output logic          panic
);

  logic [CW-1:0] lv, rq, pn;
  logic          urgent;

  assign lv = CW'(level);
  assign rq = CW'(req_lvl);
  assign pn = CW'(panic_lvl);

  generate
    if (ABOVE) begin : g_above
      assign need   = (lv > rq);
      assign urgent = (lv > pn);
    end else begin : g_below
      assign need   = (lv < rq);
      assign urgent = (lv < pn);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq  <= 1'b0;
      panic <= 1'b0;
    end else begin
      dreq  <= en && need;
      panic <= en && urgent;
    end
  end

  // R6
  dma_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!dreq && !panic));

endmodule

// File: rtl/pcm_fifo_dreq_flush.sv
module pcm_fifo_dreq_flush #(
  parameter int TICKS = 2,
  localparam int CW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic pending,
  output logic fire
);

  logic [CW-1:0] cnt;

  assign pending = (cnt != '0);
  assign fire    = tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start && !pending) begin
      cnt <= CW'(TICKS);
    end else if (tick && pending) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9
  flush_window_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !pending);

endmodule

// File: rtl/pcm_fifo_dreq.sv
module pcm_fifo_dreq
  import pcm_fifo_dreq_pkg::*;
#(
  parameter int DW          = 32,
  parameter int DEPTH       = 64,
  parameter int FW          = 8,
  parameter int CLR_TICKS   = 2,
  parameter int ECHO_STAGES = 2,
  localparam int LW         = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [2:0]    cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  input  logic          pcm_tick,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          tx_dreq,
  output logic          tx_panic,
  output logic          rx_dreq,
  output logic          rx_panic,
  output logic          irq
);

  logic tx_on, rx_on, dma_en, tx_err, rx_err, echo_req;
  logic [ECHO_STAGES-1:0] echo_pipe;
  logic [31:0]            levels;
  logic [IRQ_W-1:0]       irq_en, irq_cond;

  logic wr_ctrl, wr_data, rd_data;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_need, rx_need;
  logic tx_pend, rx_pend, tx_fire, rx_fire;
  logic tx_take, rx_take, echo_rb;
  logic [DW-1:0] rx_word;
  logic [31:0]   ctrl_view, rd_reg;
  logic          rd_from_fifo;

  assign wr_ctrl = cpu_wr && (cpu_addr == RA_CTRL);
  assign wr_data = cpu_wr && (cpu_addr == RA_DATA);
  assign rd_data = cpu_rd && (cpu_addr == RA_DATA);
  assign tx_take = tx_pop && tx_on;
  assign rx_take = rx_push && rx_on;
  assign echo_rb = echo_pipe[ECHO_STAGES-1];

  pcm_fifo_dreq_store #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_fire),
    .push(wr_data), .wdata(cpu_wdata[DW-1:0]),
    .pop(tx_take), .rdata(tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  pcm_fifo_dreq_store #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_fire),
    .push(rx_take), .wdata(rx_data),
    .pop(rd_data), .rdata(rx_word),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  pcm_fifo_dreq_mark #(.LW(LW), .FW(FW), .ABOVE(1'b0)) u_txmark (
    .clk(clk), .rst(rst), .en(dma_en), .level(tx_lvl),
    .req_lvl(levels[8 +: FW]), .panic_lvl(levels[24 +: FW]),
    .need(tx_need), .dreq(tx_dreq), .panic(tx_panic)
  );

  pcm_fifo_dreq_mark #(.LW(LW), .FW(FW), .ABOVE(1'b1)) u_rxmark (
    .clk(clk), .rst(rst), .en(dma_en), .level(rx_lvl),
    .req_lvl(levels[0 +: FW]), .panic_lvl(levels[16 +: FW]),
    .need(rx_need), .dreq(rx_dreq), .panic(rx_panic)
  );

  pcm_fifo_dreq_flush #(.TICKS(CLR_TICKS)) u_txclr (
    .clk(clk), .rst(rst), .start(wr_ctrl && cpu_wdata[B_TXCLR]),
    .tick(pcm_tick), .pending(tx_pend), .fire(tx_fire)
  );

  pcm_fifo_dreq_flush #(.TICKS(CLR_TICKS)) u_rxclr (
    .clk(clk), .rst(rst), .start(wr_ctrl && cpu_wdata[B_RXCLR]),
    .tick(pcm_tick), .pending(rx_pend), .fire(rx_fire)
  );

  // control and level registers, sticky errors with write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_on    <= 1'b0;
      rx_on    <= 1'b0;
      dma_en   <= 1'b0;
      echo_req <= 1'b0;
      tx_err   <= 1'b0;
      rx_err   <= 1'b0;
      levels   <= LEVELS_RST;
      irq_en   <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_on    <= cpu_wdata[B_TXON];
        rx_on    <= cpu_wdata[B_RXON];
        dma_en   <= cpu_wdata[B_DMAEN];
        echo_req <= cpu_wdata[B_ECHO];
      end
      if (cpu_wr && cpu_addr == RA_LEVELS) levels <= cpu_wdata;
      if (cpu_wr && cpu_addr == RA_IRQEN)  irq_en <= cpu_wdata[IRQ_W-1:0];
      if (tx_take && tx_empty)            tx_err <= 1'b1;
      else if (wr_ctrl && cpu_wdata[B_TXERR]) tx_err <= 1'b0;
      if (rx_take && rx_full)             rx_err <= 1'b1;
      else if (wr_ctrl && cpu_wdata[B_RXERR]) rx_err <= 1'b0;
    end
  end

  // echo bit crosses the PCM edges before it is visible
  always_ff @(posedge clk) begin
    if (rst) echo_pipe <= '0;
    else if (pcm_tick) echo_pipe <= {echo_pipe[ECHO_STAGES-2:0], echo_req};
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[B_RXON]  = rx_on;
    ctrl_view[B_TXON]  = tx_on;
    ctrl_view[B_TXCLR] = tx_pend;
    ctrl_view[B_RXCLR] = rx_pend;
    ctrl_view[B_DMAEN] = dma_en;
    ctrl_view[B_TXERR] = tx_err;
    ctrl_view[B_RXERR] = rx_err;
    ctrl_view[B_TXW]   = tx_need;
    ctrl_view[B_RXR]   = rx_need;
    ctrl_view[B_RXD]   = !rx_empty;
    ctrl_view[B_TXE]   = tx_empty;
    ctrl_view[B_ECHO]  = echo_rb;
  end

  always_comb begin
    irq_cond          = '0;
    irq_cond[I_TXW]   = tx_need;
    irq_cond[I_RXR]   = rx_need;
    irq_cond[I_TXERR] = tx_err;
    irq_cond[I_RXERR] = rx_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg       <= '0;
      rd_from_fifo <= 1'b0;
      irq          <= 1'b0;
    end else begin
      irq <= |(irq_en & irq_cond);
      if (cpu_rd) begin
        rd_from_fifo <= (cpu_addr == RA_DATA);
        case (cpu_addr)
          RA_CTRL:   rd_reg <= ctrl_view;
          RA_LEVELS: rd_reg <= levels;
          RA_IRQEN:  rd_reg <= 32'(irq_en);
          RA_IRQST:  rd_reg <= 32'(irq_cond);
          default:   rd_reg <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata = rd_from_fifo ? 32'(rx_word) : rd_reg;

  // R8
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !(wr_ctrl && cpu_wdata[B_TXERR])) |=> tx_err);

  // R8
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !(wr_ctrl && cpu_wdata[B_RXERR])) |=> rx_err);

  // R10
  echo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pcm_tick |=> $stable(echo_rb));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq);

  // R12
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_on && !wr_data && !tx_fire) |=> $stable(tx_lvl));

endmodule

// File: tb/sim_pcm_fifo_dreq.sv
module sim_pcm_fifo_dreq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        pcm_tick = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
  logic [31:0] tx_data, rx_data = '0;
  logic        tx_dreq, tx_panic, rx_dreq, rx_panic, irq;

  always #4 clk = ~clk;

  pcm_fifo_dreq u0 (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pcm_tick(pcm_tick), .tx_pop(tx_pop), .tx_data(tx_data),
    .rx_push(rx_push), .rx_data(rx_data),
    .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq),
    .rx_panic(rx_panic), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model
  logic [31:0] txq[$], rxq[$];
  logic [31:0] m_lv = 32'h1030_3020;
  logic m_txon = 0, m_rxon = 0, m_dma = 0, m_txerr = 0, m_rxerr = 0;
  logic m_echo = 0, m_echo_rb = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(logic pt, logic pr);
    logic [31:0] v = '0;
    v[1] = m_rxon; v[2] = m_txon; v[3] = pt; v[4] = pr; v[9] = m_dma;
    v[15] = m_txerr; v[16] = m_rxerr;
    v[17] = txq.size() < int'(m_lv[15:8]);
    v[18] = rxq.size() > int'(m_lv[7:0]);
    v[20] = rxq.size() != 0;
    v[21] = txq.size() == 0;
    v[24] = m_echo_rb;
    return v;
  endfunction

  function automatic logic [31:0] req_word();
    logic [31:0] v = '0;
    v[3] = m_dma && (txq.size() < int'(m_lv[15:8]));
    v[2] = m_dma && (txq.size() < int'(m_lv[31:24]));
    v[1] = m_dma && (rxq.size() > int'(m_lv[7:0]));
    v[0] = m_dma && (rxq.size() > int'(m_lv[23:16]));
    return v;
  endfunction

  function automatic logic [31:0] irq_cond();
    logic [31:0] v = '0;
    v[0] = txq.size() < int'(m_lv[15:8]);
    v[1] = rxq.size() > int'(m_lv[7:0]);
    v[2] = m_txerr; v[3] = m_rxerr;
    return v;
  endfunction

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic tick();
    pcm_tick = 1; @(negedge clk); pcm_tick = 0;
  endtask

  task automatic set_ctrl(logic [31:0] extra);
    logic [31:0] v = extra;
    v[1] = m_rxon; v[2] = m_txon; v[9] = m_dma; v[24] = m_echo;
    if (extra[15]) m_txerr = 0;
    if (extra[16]) m_rxerr = 0;
    bus_wr(3'd0, v);
  endtask

  task automatic check_ctrl(string req, logic pt, logic pr);
    logic [31:0] d;
    bus_rd(3'd0, d);
    chk(req, d, ctrl_word(pt, pr));
  endtask

  task automatic check_req(string req);
    @(negedge clk);
    chk(req, {28'd0, tx_dreq, tx_panic, rx_dreq, rx_panic}, req_word());
  endtask

  task automatic m_tx_write(logic [31:0] d);
    if (txq.size() < 64) txq.push_back(d);
    bus_wr(3'd1, d);
  endtask

  task automatic m_tx_pop();
    logic [31:0] e = '0;
    logic have = 0;
    if (m_txon) begin
      if (txq.size() == 0) m_txerr = 1;
      else begin e = txq.pop_front(); have = 1; end
    end
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    if (have) chk("R2 tx order", tx_data, e);
  endtask

  task automatic m_rx_push(logic [31:0] d);
    if (m_rxon) begin
      if (rxq.size() == 64) m_rxerr = 1;
      else rxq.push_back(d);
    end
    rx_push = 1; rx_data = d; @(negedge clk); rx_push = 0;
  endtask

  task automatic m_rx_read();
    logic [31:0] e = '0, d;
    logic have = 0;
    if (rxq.size() != 0) begin e = rxq.pop_front(); have = 1; end
    bus_rd(3'd1, d);
    if (have) chk("R3 rx order", d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {27'd0, tx_dreq, tx_panic, rx_dreq, rx_panic, irq}, 32'd0);
    bus_rd(3'd0, d); chk("R1 ctrl", d, 32'h0022_0000);
    bus_rd(3'd2, d); chk("R1 levels", d, 32'h1030_3020);

    // R12 gating while off
    m_tx_pop();
    m_rx_push(32'hDEAD_0001);
    check_ctrl("R12 off ignored", 0, 0);

    // enable, R4 R6
    check_req("R6 dma off");
    m_txon = 1; m_rxon = 1; m_dma = 1;
    set_ctrl(32'd0);
    check_req("R4 enable");

    // random phase, R2 R3 R4 R5 R8
    for (int i = 0; i < 600; i++) begin
      int bias = (i % 200 < 110) ? 7 : 3;
      if (i % 150 == 75) begin
        m_lv = {8'($urandom % 65), 8'($urandom % 65), 8'($urandom % 65), 8'($urandom % 65)};
        bus_wr(3'd2, m_lv);
      end
      if ($urandom % 2 == 0) begin
        if (int'($urandom % 10) < bias) m_tx_write($urandom);
        else m_tx_pop();
        check_req("R4 tx levels");
      end else begin
        if (int'($urandom % 10) < bias) m_rx_push($urandom);
        else m_rx_read();
        check_req("R5 rx levels");
      end
      if (i % 50 == 0) check_ctrl("R7 flags", 0, 0);
    end

    // restore default levels, clear errors
    m_lv = 32'h1030_3020; bus_wr(3'd2, m_lv);
    set_ctrl(32'h0001_8000);
    check_ctrl("R8 w1c", 0, 0);

    // R9 flush timing
    for (int k = 0; k < 3; k++) begin m_tx_write(32'hA0 + k); m_rx_push(32'hB0 + k); end
    set_ctrl(32'h0000_0018);
    check_ctrl("R9 pending", 1, 1);
    tick();
    check_ctrl("R9 kept after one tick", 1, 1);
    tick();
    txq.delete(); rxq.delete();
    check_ctrl("R9 flushed", 0, 0);
    check_req("R9 dreq after flush");

    // R8 underrun
    m_tx_pop();
    check_ctrl("R8 tx underrun", 0, 0);
    set_ctrl(32'h0000_8000);
    check_ctrl("R8 tx clear", 0, 0);
    // R8 overflow with drop
    for (int k = 0; k < 65; k++) m_rx_push(32'h100 + k);
    check_ctrl("R8 rx overflow", 0, 0);
    for (int k = 0; k < 64; k++) m_rx_read();
    check_ctrl("R3 drained", 0, 0);
    // R3 read of empty removes nothing
    m_rx_read();
    m_rx_push(32'h0000_5A5A);
    m_rx_read();
    check_ctrl("R3 empty read", 0, 0);
    set_ctrl(32'h0001_0000);

    // R2 full write ignored
    for (int k = 0; k < 66; k++) m_tx_write(32'h200 + k);
    check_ctrl("R2 full", 0, 0);
    for (int k = 0; k < 64; k++) m_tx_pop();
    check_ctrl("R2 drained", 0, 0);

    // R10 echo
    m_echo = 1; set_ctrl(32'd0);
    check_ctrl("R10 before ticks", 0, 0);
    tick();
    check_ctrl("R10 after one tick", 0, 0);
    tick();
    m_echo_rb = 1;
    check_ctrl("R10 after two ticks", 0, 0);

    // R11 interrupts
    bus_rd(3'd4, d); chk("R11 status", d, irq_cond());
    bus_wr(3'd3, 32'h1);
    @(negedge clk); chk("R11 txw irq", {31'd0, irq}, 32'd1);
    bus_wr(3'd3, 32'h0);
    @(negedge clk); chk("R11 masked", {31'd0, irq}, 32'd0);
    bus_wr(3'd3, 32'h4);
    @(negedge clk); chk("R11 no err yet", {31'd0, irq}, 32'd0);
    m_tx_pop();
    @(negedge clk); chk("R11 err irq", {31'd0, irq}, 32'd1);
    bus_rd(3'd4, d); chk("R11 status err", d, irq_cond());

    // R6 dma off with levels that would request
    m_dma = 0; set_ctrl(32'd0);
    check_req("R6 dma off");
    // R12 off again
    m_txon = 0; m_rxon = 0; set_ctrl(32'd0);
    m_rx_push(32'h7777_0000);
    m_tx_pop();
    check_ctrl("R12 off again", 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule